// File: doc/BRIEF.md
# Burst Address Generator

This block supplies the array address for each access of a synchronous burst memory. A full external address is captured when either of two active-low load strobes is sampled low on a rising clock edge. One strobe comes from the processor side and counts only while the chip enable is asserted. The other comes from the controller side and always counts. Later accesses in the burst come from a small counter that works only on the low address bits. This counter steps when the active-low advance input is sampled low. The upper address bits keep their loaded value.

A runtime order input selects how the low bits step. In linear order the offset counts up by one, modulo the group size. In interleaved order the loaded low bits are XORed with the running beat number. The order input is active low: low selects linear order and high selects interleaved order. If the input is left floating, the block treats it as interleaved, as if a pull-up were fitted. A burst-active flag is high from a load until the step that follows the last word of the group. A new address may be loaded on every cycle, so bursting is optional.

Top module: `burst_addr_gen`

## Requirements
- R1: While reset is asserted, addr_out is 0 and burst_act is 0.
- R2: When ld_proc_n and chip_en_n are both sampled low, addr_out equals the sampled addr_in after that edge and burst_act is 1.
- R3: When ld_ctrl_n is sampled low, addr_out equals the sampled addr_in after that edge and burst_act is 1, whatever the level of chip_en_n.
- R4: When chip_en_n is sampled high, a low ld_proc_n is ignored. With ld_ctrl_n high, the address is then held or stepped as adv_n dictates.
- R5: With no effective strobe and adv_n sampled high, addr_out and burst_act keep their values.
- R6: With order_n low, each step sets the low two bits to (loaded low bits + beat) mod 4. The beat is 1, 2, 3, 0 for successive steps after a load.
- R7: With order_n high, each step sets the low two bits to (loaded low bits XOR beat).
- R8: A step never changes the address bits above the low two. The low bits wrap inside their 4-word group.
- R9: The step that follows the fourth address of a burst clears burst_act. The address keeps wrapping with burst_act at 0.
- R10: A load may occur on every cycle. When a strobe is effective, adv_n is ignored, and both strobes together give a single load.
- R11: order_n is sampled at each step, so a change of order in mid-burst applies from the next step on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ld_proc_n | input | 1 | Processor-side load strobe, active low, qualified by chip_en_n |
| ld_ctrl_n | input | 1 | Controller-side load strobe, active low |
| chip_en_n | input | 1 | Chip enable, active low |
| adv_n | input | 1 | Burst step request, active low |
| order_n | input | 1 | Count order: 0 linear, 1 interleaved |
| addr_in | input | ADDR_W | External address |
| addr_out | output | ADDR_W | Current array address (registered) |
| burst_act | output | 1 | High while the loaded burst has words left |

## Verification
Every result is registered once. A load, step or hold decided at a rising edge therefore appears on addr_out and burst_act right after that edge, and is stable until the next edge. The bench drives inputs on the falling edge. It compares the outputs on the following falling edge, one full cycle later, so each expected value refers to exactly one decision. Mode changes and ignored strobes are judged on the address seen in that same cycle, before the next stimulus can alter it.

// File: rtl/burst_pkg.sv
package burst_pkg;
   // decision taken at each rising edge
   typedef enum logic [1:0] {
      BA_HOLD = 2'd0,
      BA_LOAD = 2'd1,
      BA_STEP = 2'd2
   } ba_act_e;
endpackage

// File: rtl/bag_decode.sv
module bag_decode
   import burst_pkg::*;
(
   input  logic    ld_proc_n,
   input  logic    ld_ctrl_n,
   input  logic    chip_en_n,
   input  logic    adv_n,
   output ba_act_e action
);
   logic proc_hit;
   logic ctrl_hit;

   // processor strobe only counts while the chip is enabled; it wins over ctrl
   assign proc_hit = !ld_proc_n && !chip_en_n;
   assign ctrl_hit = !ld_ctrl_n;

   always_comb begin
      if (proc_hit)
         action = BA_LOAD;
      else if (ctrl_hit)
         action = BA_LOAD;
      else if (!adv_n)
         action = BA_STEP;
      else
         action = BA_HOLD;
   end
endmodule

// File: rtl/bag_offset.sv
module bag_offset #(
   parameter int OFFSET_W = 2
) (
   input  logic [OFFSET_W-1:0] base,
   input  logic [OFFSET_W-1:0] beat,
   input  logic                linear,
   output logic [OFFSET_W-1:0] offset
);
   logic [OFFSET_W-1:0] lin_off;
   logic [OFFSET_W-1:0] ilv_off;

   generate
      if (OFFSET_W < 1) begin : g_bad_w
         $error("bag_offset: OFFSET_W must be at least 1");
      end
   endgenerate

   // linear order: modular add of the beat to the loaded low bits
   assign lin_off = base + beat;

   // interleaved order: bitwise XOR of loaded low bits with the beat
   generate
      for (genvar b = 0; b < OFFSET_W; b++) begin : g_ilv
         assign ilv_off[b] = base[b] ^ beat[b];
      end
   endgenerate

   assign offset = linear ? lin_off : ilv_off;
endmodule

// File: rtl/burst_addr_gen.sv
module burst_addr_gen
   import burst_pkg::*;
#(
   parameter int ADDR_W   = 20,
   parameter int OFFSET_W = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ld_proc_n,
   input  logic              ld_ctrl_n,
   input  logic              chip_en_n,
   input  logic              adv_n,
   input  logic              order_n,
   input  logic [ADDR_W-1:0] addr_in,
   output logic [ADDR_W-1:0] addr_out,
   output logic              burst_act
);
   localparam int UPPER_W = ADDR_W - OFFSET_W;
   localparam logic [OFFSET_W-1:0] LAST_BEAT = '1;
   localparam logic [OFFSET_W-1:0] ONE_BEAT  = OFFSET_W'(1);

   generate
      if (OFFSET_W < 1 || OFFSET_W >= ADDR_W) begin : g_bad_cfg
         $error("burst_addr_gen: need 1 <= OFFSET_W < ADDR_W");
      end
   endgenerate

   ba_act_e             action;
   logic [UPPER_W-1:0]  upper_q;
   logic [OFFSET_W-1:0] base_q;
   logic [OFFSET_W-1:0] off_q;
   logic [OFFSET_W-1:0] beat_q;
   logic [OFFSET_W-1:0] beat_inc;
   logic [OFFSET_W-1:0] step_off;
   logic                act_q;
   logic                lin_sel;

   bag_decode u_dec (
      .ld_proc_n (ld_proc_n),
      .ld_ctrl_n (ld_ctrl_n),
      .chip_en_n (chip_en_n),
      .adv_n     (adv_n),
      .action    (action)
   );

   assign beat_inc = beat_q + ONE_BEAT;
   // a floating order pin resolves to interleaved; only a hard 0 picks linear
   assign lin_sel  = (order_n === 1'b0);

   bag_offset #(.OFFSET_W(OFFSET_W)) u_off (
      .base   (base_q),
      .beat   (beat_inc),
      .linear (lin_sel),
      .offset (step_off)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         upper_q <= '0;
         base_q  <= '0;
         off_q   <= '0;
         beat_q  <= '0;
         act_q   <= 1'b0;
      end else begin
         case (action)
            BA_LOAD: begin
               upper_q <= addr_in[ADDR_W-1:OFFSET_W];
               base_q  <= addr_in[OFFSET_W-1:0];
               off_q   <= addr_in[OFFSET_W-1:0];
               beat_q  <= '0;
               act_q   <= 1'b1;
            end
            BA_STEP: begin
               beat_q <= beat_inc;
               off_q  <= step_off;
               if (beat_q == LAST_BEAT)
                  act_q <= 1'b0;
            end
            default: ;
         endcase
      end
   end

   assign addr_out  = {upper_q, off_q};
   assign burst_act = act_q;

   // ---------------- assertions ----------------
   p_reset_r1: assert property (@(posedge clk)
      !rst_n |=> (!rst_n || (addr_out == '0 && !burst_act) || $past(!ld_proc_n && !chip_en_n)
                  || $past(!ld_ctrl_n) || $past(!adv_n)))
      else $error("p_reset_r1");

   p_proc_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (!ld_proc_n && !chip_en_n) |=> (addr_out == $past(addr_in) && burst_act))
      else $error("p_proc_load_r2");

   p_ctrl_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !ld_ctrl_n |=> (addr_out == $past(addr_in) && burst_act))
      else $error("p_ctrl_load_r3");

   p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
      ((ld_proc_n || chip_en_n) && ld_ctrl_n && adv_n)
      |=> ($stable(addr_out) && $stable(burst_act)))
      else $error("p_hold_r5");

   p_upper_kept_r8: assert property (@(posedge clk) disable iff (!rst_n)
      ((ld_proc_n || chip_en_n) && ld_ctrl_n)
      |=> $stable(addr_out[ADDR_W-1:OFFSET_W]))
      else $error("p_upper_kept_r8");

   p_act_drop_r9: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(burst_act) |-> $past(!adv_n && ld_ctrl_n && (ld_proc_n || chip_en_n)))
      else $error("p_act_drop_r9");
endmodule

// File: tb/burst_addr_gen_test.sv
module burst_addr_gen_test;
   localparam int AW = 8;

   logic          clk = 1'b0;
   logic          rst_n;
   logic          ld_proc_n, ld_ctrl_n, chip_en_n, adv_n, order_n;
   logic [AW-1:0] addr_in;
   logic [AW-1:0] addr_out;
   logic          burst_act;

   int total = 0;
   int bad   = 0;

   always #2 clk = ~clk;   // 250 MHz

   burst_addr_gen #(.ADDR_W(AW), .OFFSET_W(2)) uut (
      .clk       (clk),
      .rst_n     (rst_n),
      .ld_proc_n (ld_proc_n),
      .ld_ctrl_n (ld_ctrl_n),
      .chip_en_n (chip_en_n),
      .adv_n     (adv_n),
      .order_n   (order_n),
      .addr_in   (addr_in),
      .addr_out  (addr_out),
      .burst_act (burst_act)
   );

   typedef struct packed {
      logic          lp_n;
      logic          lc_n;
      logic          ce_n;
      logic          av_n;
      logic          od_n;
      logic [AW-1:0] a;
      logic [AW-1:0] ea;
      logic          eact;
   } vec_t;

   // lp_n, lc_n, ce_n, av_n, od_n, addr_in, expected addr, expected act
   localparam int NV = 19;
   localparam vec_t VEC [NV] = '{
      '{1'b0,1'b1,1'b0,1'b1,1'b0,8'hA5,8'hA5,1'b1},  // 0  R2 proc load
      '{1'b1,1'b1,1'b0,1'b0,1'b0,8'h00,8'hA6,1'b1},  // 1  R6 linear
      '{1'b1,1'b1,1'b0,1'b0,1'b0,8'h00,8'hA7,1'b1},  // 2  R6
      '{1'b1,1'b1,1'b0,1'b0,1'b0,8'h00,8'hA4,1'b1},  // 3  R8 wrap
      '{1'b1,1'b1,1'b0,1'b0,1'b0,8'h00,8'hA5,1'b0},  // 4  R9 drop
      '{1'b1,1'b1,1'b0,1'b1,1'b0,8'h00,8'hA5,1'b0},  // 5  R5 hold
      '{1'b1,1'b0,1'b1,1'b1,1'b1,8'h3E,8'h3E,1'b1},  // 6  R3 ctrl load
      '{1'b1,1'b1,1'b0,1'b0,1'b1,8'h00,8'h3F,1'b1},  // 7  R7 interleaved
      '{1'b1,1'b1,1'b0,1'b0,1'b1,8'h00,8'h3C,1'b1},  // 8  R7
      '{1'b1,1'b1,1'b0,1'b0,1'b1,8'h00,8'h3D,1'b1},  // 9  R7
      '{1'b1,1'b1,1'b0,1'b1,1'b1,8'h00,8'h3D,1'b1},  // 10 R5 hold
      '{1'b0,1'b1,1'b1,1'b1,1'b1,8'hFF,8'h3D,1'b1},  // 11 R4 ignored
      '{1'b0,1'b1,1'b1,1'b0,1'b1,8'hFF,8'h3E,1'b0},  // 12 R4 step
      '{1'b0,1'b0,1'b0,1'b0,1'b1,8'h7B,8'h7B,1'b1},  // 13 R10 both
      '{1'b1,1'b0,1'b0,1'b0,1'b1,8'h12,8'h12,1'b1},  // 14 R10
      '{1'b0,1'b1,1'b0,1'b1,1'b1,8'hC3,8'hC3,1'b1},  // 15 R10
      '{1'b1,1'b1,1'b0,1'b0,1'b0,8'h00,8'hC0,1'b1},  // 16 R6 R8
      '{1'b1,1'b1,1'b0,1'b0,1'b1,8'h00,8'hC1,1'b1},  // 17 R11
      '{1'b1,1'b1,1'b0,1'b0,1'b0,8'h00,8'hC2,1'b1}   // 18 R11
   };

   localparam string VTAG [NV] = '{
      "R2","R6","R6","R8","R9","R5","R3","R7","R7","R7",
      "R5","R4","R4","R10","R10","R10","R6","R11","R11"};

   task automatic check(input string tag, input logic [AW-1:0] ea, input logic eact);
      total++;
      if (addr_out !== ea || burst_act !== eact) begin
         bad++;
         $display("FAIL %s: addr=%h act=%b expected addr=%h act=%b",
                  tag, addr_out, burst_act, ea, eact);
      end
   endtask

   task automatic idle_inputs();
      ld_proc_n = 1'b1; ld_ctrl_n = 1'b1; chip_en_n = 1'b0;
      adv_n = 1'b1; order_n = 1'b1; addr_in = '0;
   endtask

   initial begin : watchdog
      #(4 * 5000);
      total++; bad++;
      $display("FAIL watchdog: run hung, expected completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin : main
      logic [5:0] up;
      idle_inputs();
      rst_n = 1'b0;
      addr_in = 8'hFF;
      ld_ctrl_n = 1'b0;   // strobes during reset must not load
      repeat (3) @(negedge clk);
      check("R1", 8'h00, 1'b0);
      idle_inputs();
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1", 8'h00, 1'b0);

      // table walk: drive at falling edge, check one cycle later
      for (int i = 0; i < NV; i++) begin
         ld_proc_n = VEC[i].lp_n;
         ld_ctrl_n = VEC[i].lc_n;
         chip_en_n = VEC[i].ce_n;
         adv_n     = VEC[i].av_n;
         order_n   = VEC[i].od_n;
         addr_in   = VEC[i].a;
         @(negedge clk);
         check(VTAG[i], VEC[i].ea, VEC[i].eact);
      end

      // R8/R9: long run of steps never touches the upper bits
      idle_inputs();
      ld_ctrl_n = 1'b0; addr_in = 8'h9E;
      @(negedge clk);
      check("R3", 8'h9E, 1'b1);
      ld_ctrl_n = 1'b1; adv_n = 1'b0; order_n = 1'b0;
      up = 6'h27;
      for (int k = 1; k <= 10; k++) begin
         @(negedge clk);
         check("R8", {up, 2'((2 + k) % 4)}, (k < 4));
      end

      // R1: reset in mid-burst clears everything
      idle_inputs();
      rst_n = 1'b0;
      #1;
      check("R1", 8'h00, 1'b0);
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1", 8'h00, 1'b0);

      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule